// File: doc/BRIEF.md
# Template Likelihood Correlator with Maximum Search

This block scores an event of quantized photon arrival times against a bank of stored likelihood templates. Each template is a table addressed by a 1 ns time bin. For every accepted hit, the entry at the hit's bin is read from every template and added to that template's running score. When the event is complete, a maximum search picks the template with the highest score. Its index stands for an estimated event time and position, and the winning score is exported as a confidence value.

Scoring uses a time-shared pool of correlation engines. There are half as many engines as templates. Engine `e` serves template `e` in the first cycle of a hit and template `e + N_ENG` in the second cycle, so a single saturating adder per engine covers two scores. The core clock is twice the hit rate, so this sharing costs no throughput. Templates are loaded through a write port that is honoured only while the block is idle.

The control FSM has five states. `ST_IDLE` waits for a start pulse, then takes transition IDLE->COLLECT, which clears all scores. `ST_COLLECT` waits for a hit or the end marker. A hit takes COLLECT->UPPER and adds the lower-half templates in that cycle. `ST_UPPER` adds the upper-half templates and always returns by UPPER->COLLECT. The end marker takes COLLECT->SEARCH. `ST_SEARCH` compares one score per cycle and takes SEARCH->REPORT after the last template. `ST_REPORT` registers the result and takes REPORT->IDLE.

Top module: `tc_corr_top`

## Requirements
- R1: After reset, busy_o, done_o, best_idx_o and best_score_o are all 0.
- R2: While busy_o is low, a cycle with wr_en_i high stores wr_data_i in template wr_tmpl_i at bin wr_addr_i. Later events score with the stored value.
- R3: A write presented while busy_o is high is dropped, and the template entry keeps its previous value.
- R4: start_i in ST_IDLE clears every score to 0 and raises busy_o. start_i seen while busy_o is high is ignored, and the scores gathered so far are kept.
- R5: A hit_valid_i seen in ST_COLLECT adds, for every template t, entry t[hit_bin_i] to score t. The add takes two cycles: templates 0..N_ENG-1 in the first, templates N_ENG..2*N_ENG-1 in the second. A hit_valid_i in that second cycle is ignored, and a hit takes priority over end_i in the same cycle.
- R6: A score saturates at 2^SCW-1 (SCW = 24 by default, 16777215) and never wraps.
- R7: end_i seen in ST_COLLECT starts the search. best_idx_o is the template with the largest score, and equal scores go to the lowest index.
- R8: best_score_o equals the score of the template reported in best_idx_o.
- R9: done_o is a one-cycle pulse on the (2*N_ENG+1)-th rising edge after the edge that sampled end_i. best_idx_o and best_score_o hold their values until the next done_o.
- R10: An event with no hits reports template 0 with score 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the hit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new event and clear the scores |
| hit_valid_i | input | 1 | A hit time is present on hit_bin_i |
| hit_bin_i | input | 6 | Quantized hit time bin |
| end_i | input | 1 | No more hits in this event |
| wr_en_i | input | 1 | Template write strobe |
| wr_tmpl_i | input | 3 | Template index to write |
| wr_addr_i | input | 6 | Bin index to write |
| wr_data_i | input | 20 | Template entry value |
| busy_o | output | 1 | An event is being gathered or searched |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| best_idx_o | output | 3 | Index of the best-matching template |
| best_score_o | output | 24 | Score of that template |

## Verification
Random events of 1 to 16 hits over random templates cover both engine phases. They show whether the lower-half and upper-half scores both reach the right template. Directed events separate the remaining behaviours. Equal leading scores test the low-index rule. An empty event tests the zero result. Twenty full-scale hits test saturation against wrap-around. A held hit_valid_i shows whether the second engine phase accepts a spurious hit. A write, and a second start_i, issued in the middle of an event show whether the memory and the scores are protected.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_UPPER   = 3'd2,
        ST_SEARCH  = 3'd3,
        ST_REPORT  = 3'd4
    } tc_state_e;

endpackage

// File: rtl/tc_bank.sv
module tc_bank #(
    parameter int N_TMPL = 8,
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 20,
    localparam int BIN_W = $clog2(DEPTH),
    localparam int IDX_W = $clog2(N_TMPL)
) (
    input  logic                              clk_i,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  wtmpl_i,
    input  logic [BIN_W-1:0]                  waddr_i,
    input  logic [WIDTH-1:0]                  wdata_i,
    input  logic [BIN_W-1:0]                  raddr_i,
    output logic [N_TMPL-1:0][WIDTH-1:0]      rdata_o
);

    logic [WIDTH-1:0] mem [N_TMPL][DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[wtmpl_i][waddr_i] <= wdata_i;
        end
    end

    // every template is read at the same bin in parallel
    for (genvar t = 0; t < N_TMPL; t++) begin : g_rd
        assign rdata_o[t] = mem[t][raddr_i];
    end

endmodule

// File: rtl/tc_engine.sv
module tc_engine #(
    parameter int WIDTH = 20,
    parameter int SCW   = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             add_lo_i,
    input  logic             add_hi_i,
    input  logic [WIDTH-1:0] val_lo_i,
    input  logic [WIDTH-1:0] val_hi_i,
    output logic [SCW-1:0]   score_lo_o,
    output logic [SCW-1:0]   score_hi_o
);

    localparam logic [SCW-1:0] SAT = {SCW{1'b1}};

    logic [SCW-1:0] lo_q, hi_q;
    logic [SCW-1:0] acc_in;
    logic [WIDTH-1:0] addend;
    logic [SCW:0]   sum;
    logic [SCW-1:0] sat_sum;

    // one adder, shared between the two templates of this engine
    always_comb begin
        acc_in  = add_hi_i ? hi_q : lo_q;
        addend  = add_hi_i ? val_hi_i : val_lo_i;
        sum     = {1'b0, acc_in} + (SCW + 1)'(addend);
        sat_sum = sum[SCW] ? SAT : sum[SCW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (clr_i) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (add_hi_i) begin
            hi_q <= sat_sum;
        end else if (add_lo_i) begin
            lo_q <= sat_sum;
        end
    end

    assign score_lo_o = lo_q;
    assign score_hi_o = hi_q;

endmodule

// File: rtl/tc_argmax.sv
module tc_argmax #(
    parameter int N_TMPL = 8,
    parameter int SCW    = 24,
    localparam int IDX_W = $clog2(N_TMPL)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         init_i,
    input  logic                         step_i,
    input  logic [N_TMPL-1:0][SCW-1:0]   scores_i,
    output logic [IDX_W-1:0]             best_idx_o,
    output logic [SCW-1:0]               best_score_o,
    output logic                         last_o
);

    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] bidx_q;
    logic [SCW-1:0]   best_q;

    // strict greater-than keeps the lowest index on equal scores
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            bidx_q <= '0;
            best_q <= '0;
        end else if (init_i) begin
            cnt_q  <= '0;
            bidx_q <= '0;
            best_q <= '0;
        end else if (step_i) begin
            if (scores_i[cnt_q] > best_q) begin
                best_q <= scores_i[cnt_q];
                bidx_q <= cnt_q;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o       = (cnt_q == IDX_W'(N_TMPL - 1));
    assign best_idx_o   = bidx_q;
    assign best_score_o = best_q;

endmodule

// File: rtl/tc_corr_top.sv
module tc_corr_top
    import tc_pkg::*;
#(
    parameter int N_ENG    = 4,
    parameter int DEPTH    = 64,
    parameter int WIDTH    = 20,
    parameter int MAX_HITS = 16,
    localparam int N_TMPL  = 2 * N_ENG,
    localparam int BIN_W   = $clog2(DEPTH),
    localparam int IDX_W   = $clog2(N_TMPL),
    localparam int SCW     = $clog2(MAX_HITS * ((1 << WIDTH) - 1) + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              hit_valid_i,
    input  logic [BIN_W-1:0]  hit_bin_i,
    input  logic              end_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_tmpl_i,
    input  logic [BIN_W-1:0]  wr_addr_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  best_idx_o,
    output logic [SCW-1:0]    best_score_o
);

    tc_state_e state_q, state_d;

    logic                         eng_clr, add_lo, add_hi;
    logic                         am_init, am_step, am_last;
    logic                         bank_we;
    logic [BIN_W-1:0]             bin_q, rd_bin;
    logic [N_TMPL-1:0][WIDTH-1:0] rd_val;
    logic [N_TMPL-1:0][SCW-1:0]   score_all;
    logic [IDX_W-1:0]             am_idx;
    logic [SCW-1:0]               am_score;
    logic                         done_q;
    logic [IDX_W-1:0]             idx_q;
    logic [SCW-1:0]               score_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (hit_valid_i)  state_d = ST_UPPER;
                else if (end_i)   state_d = ST_SEARCH;
            end
            ST_UPPER:   state_d = ST_COLLECT;
            ST_SEARCH:  if (am_last) state_d = ST_REPORT;
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // control decode
    always_comb begin
        eng_clr = (state_q == ST_IDLE) && start_i;
        add_lo  = (state_q == ST_COLLECT) && hit_valid_i;
        add_hi  = (state_q == ST_UPPER);
        am_init = (state_q == ST_COLLECT) && !hit_valid_i && end_i;
        am_step = (state_q == ST_SEARCH);
        bank_we = (state_q == ST_IDLE) && wr_en_i;
        rd_bin  = (state_q == ST_UPPER) ? bin_q : hit_bin_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bin_q <= '0;
        end else if (add_lo) begin
            bin_q <= hit_bin_i;
        end
    end

    tc_bank #(
        .N_TMPL (N_TMPL),
        .DEPTH  (DEPTH),
        .WIDTH  (WIDTH)
    ) u_bank (
        .clk_i   (clk_i),
        .we_i    (bank_we),
        .wtmpl_i (wr_tmpl_i),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (rd_bin),
        .rdata_o (rd_val)
    );

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        tc_engine #(
            .WIDTH (WIDTH),
            .SCW   (SCW)
        ) u_eng (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clr_i      (eng_clr),
            .add_lo_i   (add_lo),
            .add_hi_i   (add_hi),
            .val_lo_i   (rd_val[e]),
            .val_hi_i   (rd_val[e + N_ENG]),
            .score_lo_o (score_all[e]),
            .score_hi_o (score_all[e + N_ENG])
        );
    end

    tc_argmax #(
        .N_TMPL (N_TMPL),
        .SCW    (SCW)
    ) u_argmax (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .init_i       (am_init),
        .step_i       (am_step),
        .scores_i     (score_all),
        .best_idx_o   (am_idx),
        .best_score_o (am_score),
        .last_o       (am_last)
    );

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q  <= 1'b0;
            idx_q   <= '0;
            score_q <= '0;
        end else begin
            done_q <= (state_q == ST_REPORT);
            if (state_q == ST_REPORT) begin
                idx_q   <= am_idx;
                score_q <= am_score;
            end
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign best_idx_o   = idx_q;
    assign best_score_o = score_q;

endmodule

// File: rtl/tc_corr_chk.sv
module tc_corr_chk
    import tc_pkg::*;
#(
    parameter int N_TMPL = 8,
    parameter int IDX_W  = 3,
    parameter int SCW    = 24
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  tc_state_e                  state_q,
    input  logic                       busy_o,
    input  logic                       done_o,
    input  logic [IDX_W-1:0]           best_idx_o,
    input  logic [SCW-1:0]             best_score_o,
    input  logic [N_TMPL-1:0][SCW-1:0] score_all,
    input  logic                       eng_clr,
    input  logic                       bank_we
);

    logic [SCW-1:0]   ref_best;
    logic [IDX_W-1:0] ref_idx;

    always_comb begin
        ref_best = '0;
        ref_idx  = '0;
        for (int t = 0; t < N_TMPL; t++) begin
            if (score_all[t] > ref_best) begin
                ref_best = score_all[t];
                ref_idx  = IDX_W'(t);
            end
        end
    end

    assert_wr_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_we |-> !busy_o);

    assert_frozen_scores_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH) |=> $stable(score_all));

    assert_winner_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (best_idx_o == ref_idx));

    assert_winner_score_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (best_score_o == ref_best));

    assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    for (genvar t = 0; t < N_TMPL; t++) begin : g_mono
        // no wrap: a score only grows until the next clear
        assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !eng_clr |=> (score_all[t] >= $past(score_all[t])));
    end

endmodule

bind tc_corr_top tc_corr_chk #(
    .N_TMPL (N_TMPL),
    .IDX_W  (IDX_W),
    .SCW    (SCW)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_q      (state_q),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .best_idx_o   (best_idx_o),
    .best_score_o (best_score_o),
    .score_all    (score_all),
    .eng_clr      (eng_clr),
    .bank_we      (bank_we)
);

// File: tb/tc_corr_top_tb_top.sv
`timescale 1ns/1ps
module tc_corr_top_tb_top;

    localparam int NT   = 8;
    localparam int DEP  = 64;
    localparam longint SMAX = 64'd16777215;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, hit_valid = 1'b0, end_hits = 1'b0, wr_en = 1'b0;
    logic [5:0]  hit_bin = '0, wr_addr = '0;
    logic [2:0]  wr_tmpl = '0;
    logic [19:0] wr_data = '0;
    logic        busy, done;
    logic [2:0]  best_idx;
    logic [23:0] best_score;

    int n_chk = 0;
    int n_err = 0;
    logic [19:0] model [NT][DEP];
    int hb [64];
    int nh;
    int got_idx, got_lat;
    longint got_score;

    always #2.5 clk = ~clk;

    tc_corr_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hit_valid_i(hit_valid),
        .hit_bin_i(hit_bin), .end_i(end_hits), .wr_en_i(wr_en), .wr_tmpl_i(wr_tmpl),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .busy_o(busy), .done_o(done),
        .best_idx_o(best_idx), .best_score_o(best_score)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and return just after a falling edge
    task automatic wr(input int t, input int a, input logic [19:0] d, input bit upd);
        wr_en = 1'b1; wr_tmpl = 3'(t); wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (upd) model[t][a] = d;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_hit(input int b);
        hit_valid = 1'b1; hit_bin = 6'(b);
        @(negedge clk);
        hit_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_event();
        end_hits = 1'b1;
        @(posedge clk);
        #1 end_hits = 1'b0;
        got_lat = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            #1;
            got_lat++;
            if (done) break;
        end
        got_idx   = int'(best_idx);
        got_score = longint'(best_score);
        @(posedge clk);
        #1 chk("R9 done width", longint'(done), 0);
        @(negedge clk);
    endtask

    function automatic void expect_result(input int n, output int ei, output longint es);
        ei = 0; es = 0;
        for (int t = 0; t < NT; t++) begin
            longint s = 0;
            for (int i = 0; i < n; i++) begin
                s += longint'(model[t][hb[i]]);
                if (s > SMAX) s = SMAX;
            end
            if (s > es) begin es = s; ei = t; end
        end
    endfunction

    task automatic run_and_check(input string tag);
        int ei; longint es;
        do_start();
        for (int i = 0; i < nh; i++) do_hit(hb[i]);
        finish_event();
        expect_result(nh, ei, es);
        chk({tag, " R7 idx"}, got_idx, ei);
        chk({tag, " R8 score"}, got_score, es);
        chk({tag, " R9 latency"}, got_lat, NT + 1);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int ei; longint es;
        void'($urandom(32'd4242));
        #1;
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
        chk("R1 idx", longint'(best_idx), 0);
        chk("R1 score", longint'(best_score), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", longint'(busy), 0);

        // load random templates (R2)
        for (int t = 0; t < NT; t++)
            for (int a = 0; a < DEP; a++)
                wr(t, a, 20'($urandom & 32'hFFFF), 1'b1);

        // random events over both engine phases (R5)
        for (int ev = 0; ev < 30; ev++) begin
            nh = 1 + int'($urandom % 16);
            for (int i = 0; i < nh; i++) hb[i] = int'($urandom % DEP);
            run_and_check("rand R5");
        end

        // R2: idle write takes effect
        wr(5, 9, 20'hFFFFF, 1'b1);
        nh = 1; hb[0] = 9;
        run_and_check("R2 write");
        chk("R2 winner", got_idx, 5);

        // R3: write while busy is dropped
        do_start();
        wr(6, 9, 20'hFFFFF, 1'b0);
        wr(6, 9, 20'hFFFFF, 1'b0);
        do_hit(9);
        finish_event();
        chk("R3 winner", got_idx, 5);
        chk("R3 score", got_score, 64'hFFFFF);
        nh = 1; hb[0] = 9;
        run_and_check("R3 recheck");

        // R4: start while busy is ignored
        do_start();
        do_hit(10);
        do_start();
        do_hit(11);
        finish_event();
        nh = 2; hb[0] = 10; hb[1] = 11;
        expect_result(nh, ei, es);
        chk("R4 idx", got_idx, ei);
        chk("R4 score kept", got_score, es);

        // R5: hit_valid held into the upper phase counts once; upper template wins
        wr(7, 13, 20'hFFFFF, 1'b1);
        wr(0, 13, 20'hFFFFE, 1'b1);
        do_start();
        hit_valid = 1'b1; hit_bin = 6'd13;
        @(negedge clk);
        @(negedge clk);
        hit_valid = 1'b0;
        finish_event();
        chk("R5 upper idx", got_idx, 7);
        chk("R5 single add", got_score, 64'hFFFFF);

        // R7: ties go to the lowest index
        for (int t = 0; t < NT; t++) wr(t, 20, (t < 3) ? 20'd500 : 20'd1000, 1'b1);
        do_start();
        do_hit(20);
        finish_event();
        chk("R7 tie idx", got_idx, 3);
        chk("R8 tie score", got_score, 1000);

        // R10: empty event; R9: outputs hold afterwards
        do_start();
        finish_event();
        chk("R10 idx", got_idx, 0);
        chk("R10 score", got_score, 0);
        chk("R9 latency empty", got_lat, NT + 1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk("R9 hold idx", longint'(best_idx), 0);
        chk("R9 hold score", longint'(best_score), 0);

        // R6: saturation
        for (int t = 0; t < NT; t++) wr(t, 30, 20'hFFFFF, 1'b1);
        nh = 20;
        for (int i = 0; i < nh; i++) hb[i] = 30;
        run_and_check("R6 sat");
        chk("R6 saturated", got_score, SMAX);
        chk("R6 idx", got_idx, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule